// File: doc/BRIEF.md
# Triggered Single-Channel DMA Transfer Engine

This block is one direct-memory-access channel. It copies data units from a source address to a destination address each time a selected trigger fires. It is set up through a set of configuration inputs that are captured on a load strobe. The configuration holds the transfer mode, the unit count, the trigger line and trigger type, the unit size and address step at each end, and both start addresses. Before each run of transfers the channel asks an external arbiter for the bus and waits for the grant. It then moves each unit with one read cycle followed by one write cycle on a byte-addressed, 16-bit memory port.

Six sequencing modes are supported: one unit per trigger, a whole block per trigger, and a whole block per trigger that releases the bus after every few units. Each of these has a repeating variant that restores the count and start addresses after completion. A completion flag is set when the programmed count is reached. The flag is gated onto an interrupt output by a separate enable and is cleared only by an explicit clear strobe.

Top module: `dma_chan_engine`

## Requirements
- R1: `cfgMode` bit 2 selects repeat, and bits [1:0] select the sequencing: 0 moves one unit per trigger, 1 moves the remaining count per trigger while holding `busReq` high throughout, and 2 or 3 do the same but drop `busReq` for one cycle after every BURST (default 4) units. A repeating mode reloads the count and both start addresses on completion and leaves the channel enabled.
- R2: A captured count of 0 produces no bus request, no memory access and no flag, whatever triggers arrive.
- R3: `flagOut` sets in the cycle after the write of the last counted unit. In a non-repeating mode `enOut` clears in that same cycle.
- R4: `cfgSrcStep`/`cfgDstStep` codes are 0 or 1 = hold, 2 = decrement, 3 = increment. The step size is 1 for a byte end and 2 for a word end, and each end is handled on its own.
- R5: Memory is little-endian: a byte at an odd address sits in lane [15:8], and a byte at an even address sits in lane [7:0]. A byte source written to a word destination has its upper byte written as zero. A word source written to a byte destination writes only its low byte, with one bit of `memBe` set. Word accesses use even addresses and `memBe` = 2'b11.
- R6: Trigger select 0 picks `swStart`, and select n (1 to 31) picks `trigIn[n]`. Lines that are not selected have no effect.
- R7: `cfgLevel` = 0 fires on a rising edge of the selected line. `cfgLevel` = 1 fires whenever the line is high while the channel is idle, so a held line keeps triggering.
- R8: `irqOut` equals `flagOut` AND `irqEn`. Setting `enSet` or `irqEn` does not clear the flag, and only `flagClr` does.
- R9: `busReq` stays high until `busGnt` is seen. Each unit then takes a `memRd` cycle followed in the next cycle by a `memWr` cycle, and `memRd` and `memWr` never occur together. Read data is expected one cycle after `memRd`.
- R10: `cfgLoad` is ignored while the channel is enabled.
- R11: After reset, `enOut`, `flagOut`, `irqOut`, `busReq`, `memRd` and `memWr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Capture the configuration inputs (only while disabled) |
| cfgMode | input | 3 | Mode code (R1) |
| cfgCount | input | CW (16) | Units per completion |
| cfgTrigSel | input | log2(NTRIG) (5) | Trigger select |
| cfgLevel | input | 1 | 1 = level trigger, 0 = rising edge |
| cfgSrcByte | input | 1 | Source unit is a byte |
| cfgDstByte | input | 1 | Destination unit is a byte |
| cfgSrcStep | input | 2 | Source address step code |
| cfgDstStep | input | 2 | Destination address step code |
| cfgSrcAddr | input | AW (16) | Source start address |
| cfgDstAddr | input | AW (16) | Destination start address |
| enSet | input | 1 | Enable the channel |
| enClr | input | 1 | Disable the channel |
| swStart | input | 1 | Software trigger (select 0) |
| trigIn | input | NTRIG (32) | Hardware trigger lines |
| irqEn | input | 1 | Interrupt enable |
| flagClr | input | 1 | Clear the completion flag |
| busReq | output | 1 | Bus request to the arbiter |
| busGnt | input | 1 | Bus grant from the arbiter |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | AW (16) | Byte address |
| memWdata | output | 16 | Write data |
| memBe | output | 2 | Byte lane enables for the write |
| memRdata | input | 16 | Read data, valid one cycle after memRd |
| enOut | output | 1 | Channel enabled |
| flagOut | output | 1 | Completion flag |
| irqOut | output | 1 | Gated interrupt |

## Verification
The checker watches the bus cycle shape on every cycle: a read is never issued without a request, every read is followed by a write, and read and write never overlap. It also checks that the flag rises only just after a write, and that an enable falling without a disable strobe always comes with the flag set. The moved data is checked by the bench scenarios, which compare all of memory against a reference copy. These cover byte and word lane placement, step directions, reload in the repeating modes, level versus edge triggering, ignored trigger lines, count-zero and the per-burst request count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_GAP
  } chan_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture configuration
    logic reload;  // restore count and start addresses
    logic step;    // advance addresses, decrement count
    logic selDst;  // drive destination address on the port
  } dp_strobe_t;

  localparam logic [1:0] STEP_DEC = 2'd2;
  localparam logic [1:0] STEP_INC = 2'd3;
endpackage

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [AW-1:0]     cfgSrcAddr,
  input  logic [AW-1:0]     cfgDstAddr,
  input  logic [CW-1:0]     cfgCount,
  input  logic              cfgSrcByte,
  input  logic              cfgDstByte,
  input  logic [1:0]        cfgSrcStep,
  input  logic [1:0]        cfgDstStep,
  input  logic [WORD_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [1:0]        memBe,
  output logic              lastUnit,
  output logic              cntZero
);
  logic [AW-1:0] srcQ, dstQ, srcBase, dstBase;
  logic [CW-1:0] cntQ, cntBase;
  logic          srcByteQ, dstByteQ;
  logic [1:0]    srcStepQ, dstStepQ;
  logic [WORD_W-1:0] unitVal;

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a,
                                             input logic [1:0] code,
                                             input logic isByte);
    logic [AW-1:0] delta;
    delta = isByte ? AW'(1) : AW'(2);
    case (code)
      STEP_INC: nextAddr = a + delta;
      STEP_DEC: nextAddr = a - delta;
      default:  nextAddr = a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0; dstQ <= '0; srcBase <= '0; dstBase <= '0;
      cntQ <= '0; cntBase <= '0;
      srcByteQ <= 1'b0; dstByteQ <= 1'b0;
      srcStepQ <= '0; dstStepQ <= '0;
    end else if (strb.load) begin
      srcQ <= cfgSrcAddr; srcBase <= cfgSrcAddr;
      dstQ <= cfgDstAddr; dstBase <= cfgDstAddr;
      cntQ <= cfgCount;   cntBase <= cfgCount;
      srcByteQ <= cfgSrcByte; dstByteQ <= cfgDstByte;
      srcStepQ <= cfgSrcStep; dstStepQ <= cfgDstStep;
    end else if (strb.reload) begin
      srcQ <= srcBase;
      dstQ <= dstBase;
      cntQ <= cntBase;
    end else if (strb.step) begin
      srcQ <= nextAddr(srcQ, srcStepQ, srcByteQ);
      dstQ <= nextAddr(dstQ, dstStepQ, dstByteQ);
      cntQ <= cntQ - CW'(1);
    end
  end

  // source unit extraction: byte lanes are little-endian
  always_comb begin
    if (srcByteQ)
      unitVal = {8'h00, srcQ[0] ? memRdata[15:8] : memRdata[7:0]};
    else
      unitVal = memRdata;
  end

  // destination placement
  always_comb begin
    if (dstByteQ) begin
      memWdata = {unitVal[7:0], unitVal[7:0]};
      memBe    = dstQ[0] ? 2'b10 : 2'b01;
    end else begin
      memWdata = unitVal;
      memBe    = 2'b11;
    end
  end

  assign memAddr  = strb.selDst ? dstQ : srcQ;
  assign lastUnit = (cntQ == CW'(1));
  assign cntZero  = (cntQ == '0);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int NTRIG = 32,
  parameter int BURST = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [2:0]               cfgMode,
  input  logic [$clog2(NTRIG)-1:0] cfgTrigSel,
  input  logic                     cfgLevel,
  input  logic                     enSet,
  input  logic                     enClr,
  input  logic                     swStart,
  input  logic [NTRIG-1:0]         trigIn,
  input  logic                     irqEn,
  input  logic                     flagClr,
  input  logic                     busGnt,
  input  logic                     lastUnit,
  input  logic                     cntZero,
  output dp_strobe_t               strb,
  output logic                     busReq,
  output logic                     memRd,
  output logic                     memWr,
  output logic                     enOut,
  output logic                     flagOut,
  output logic                     irqOut
);
  localparam int SW = $clog2(NTRIG);
  localparam int BW = $clog2(BURST);

  chan_state_t st, stN;
  logic [2:0]    modeQ;
  logic          levelQ;
  logic [SW-1:0] selQ;
  logic          enQ, flagQ, prevRaw;
  logic [BW-1:0] burstQ;
  logic          loadOk, rawSel, trigHit, setFlag, autoClr;

  assign loadOk  = cfgLoad & ~enQ;
  assign rawSel  = (selQ == '0) ? swStart : trigIn[selQ];
  assign trigHit = levelQ ? rawSel : (rawSel & ~prevRaw);

  always_comb begin
    stN     = st;
    strb    = '0;
    busReq  = 1'b0;
    memRd   = 1'b0;
    memWr   = 1'b0;
    setFlag = 1'b0;
    autoClr = 1'b0;
    strb.load = loadOk;
    case (st)
      ST_IDLE: if (enQ && trigHit && !cntZero) stN = ST_REQ;
      ST_REQ: begin
        busReq = 1'b1;
        if (!enQ)        stN = ST_IDLE;
        else if (busGnt) stN = ST_RD;
      end
      ST_RD: begin
        busReq = 1'b1;
        memRd  = 1'b1;
        stN    = ST_WR;
      end
      ST_WR: begin
        busReq      = 1'b1;
        memWr       = 1'b1;
        strb.selDst = 1'b1;
        strb.step   = 1'b1;
        if (lastUnit) begin
          setFlag = 1'b1;
          if (modeQ[2]) strb.reload = 1'b1;
          else          autoClr = 1'b1;
          stN = ST_IDLE;
        end else if (modeQ[1:0] == 2'b00 || !enQ) begin
          stN = ST_IDLE;
        end else if (modeQ[1] && burstQ == BW'(BURST - 1)) begin
          stN = ST_GAP;
        end else begin
          stN = ST_RD;
        end
      end
      ST_GAP:  stN = ST_REQ;
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      modeQ   <= '0;
      levelQ  <= 1'b0;
      selQ    <= '0;
      enQ     <= 1'b0;
      flagQ   <= 1'b0;
      prevRaw <= 1'b0;
      burstQ  <= '0;
    end else begin
      st      <= stN;
      prevRaw <= rawSel;
      if (loadOk) begin
        modeQ  <= cfgMode;
        levelQ <= cfgLevel;
        selQ   <= cfgTrigSel;
      end
      if (enClr || autoClr) enQ <= 1'b0;
      else if (enSet)       enQ <= 1'b1;
      if (setFlag)      flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
      if (st == ST_IDLE) burstQ <= '0;
      else if (st == ST_WR)
        burstQ <= (burstQ == BW'(BURST - 1)) ? '0 : burstQ + BW'(1);
    end
  end

  assign enOut   = enQ;
  assign flagOut = flagQ;
  assign irqOut  = flagQ & irqEn;
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int NTRIG = 32,
  parameter int BURST = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [2:0]               cfgMode,
  input  logic [CW-1:0]            cfgCount,
  input  logic [$clog2(NTRIG)-1:0] cfgTrigSel,
  input  logic                     cfgLevel,
  input  logic                     cfgSrcByte,
  input  logic                     cfgDstByte,
  input  logic [1:0]               cfgSrcStep,
  input  logic [1:0]               cfgDstStep,
  input  logic [AW-1:0]            cfgSrcAddr,
  input  logic [AW-1:0]            cfgDstAddr,
  input  logic                     enSet,
  input  logic                     enClr,
  input  logic                     swStart,
  input  logic [NTRIG-1:0]         trigIn,
  input  logic                     irqEn,
  input  logic                     flagClr,
  output logic                     busReq,
  input  logic                     busGnt,
  output logic                     memRd,
  output logic                     memWr,
  output logic [AW-1:0]            memAddr,
  output logic [15:0]              memWdata,
  output logic [1:0]               memBe,
  input  logic [15:0]              memRdata,
  output logic                     enOut,
  output logic                     flagOut,
  output logic                     irqOut
);
  dp_strobe_t strb;
  logic       lastUnit, cntZero;

  dma_chan_ctrl #(.NTRIG(NTRIG), .BURST(BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgTrigSel(cfgTrigSel), .cfgLevel(cfgLevel), .enSet(enSet),
    .enClr(enClr), .swStart(swStart), .trigIn(trigIn), .irqEn(irqEn),
    .flagClr(flagClr), .busGnt(busGnt), .lastUnit(lastUnit),
    .cntZero(cntZero), .strb(strb), .busReq(busReq), .memRd(memRd),
    .memWr(memWr), .enOut(enOut), .flagOut(flagOut), .irqOut(irqOut)
  );

  dma_chan_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSrcAddr(cfgSrcAddr),
    .cfgDstAddr(cfgDstAddr), .cfgCount(cfgCount), .cfgSrcByte(cfgSrcByte),
    .cfgDstByte(cfgDstByte), .cfgSrcStep(cfgSrcStep),
    .cfgDstStep(cfgDstStep), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .lastUnit(lastUnit),
    .cntZero(cntZero)
  );
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk (
  input logic clk,
  input logic rstN,
  input logic memRd,
  input logic memWr,
  input logic busReq,
  input logic flagOut,
  input logic enOut,
  input logic enClr
);
  // R9: a unit is a read cycle, then a write cycle, never both at once
  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  a_r9_rd_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busReq);
  a_r9_rd_then_wr: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> memWr);
  // R3: the flag only rises right after a write
  a_r3_flag_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOut) |-> $past(memWr));
  // R3: enable dropping on its own means the count completed
  a_r3_auto_disable_flag: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(enOut) && !$past(enClr)) |-> flagOut);
endmodule

bind dma_chan_engine dma_chan_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr), .busReq(busReq),
  .flagOut(flagOut), .enOut(enOut), .enClr(enClr)
);

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        cfgLoad = 0, cfgLevel = 0, cfgSrcByte = 0, cfgDstByte = 0;
  logic [2:0]  cfgMode = 0;
  logic [15:0] cfgCount = 0, cfgSrcAddr = 0, cfgDstAddr = 0;
  logic [4:0]  cfgTrigSel = 0;
  logic [1:0]  cfgSrcStep = 0, cfgDstStep = 0;
  logic        enSet = 0, enClr = 0, swStart = 0, irqEn = 0, flagClr = 0;
  logic [31:0] trigIn = 0;
  logic        busReq, busGnt, memRd, memWr, enOut, flagOut, irqOut;
  logic [15:0] memAddr, memWdata, memRdata;
  logic [1:0]  memBe;
  logic        gntOk = 1'b1;

  dma_chan_engine u0 (.*);

  assign busGnt = busReq & gntOk;

  // memory model: byte array, registered read
  logic [7:0]  mem    [0:511];
  logic [7:0]  expMem [0:511];
  logic [15:0] rdq = '0;
  assign memRdata = rdq;
  always @(posedge clk) begin
    if (memRd) rdq <= {mem[{memAddr[8:1], 1'b1}], mem[{memAddr[8:1], 1'b0}]};
    if (memWr) begin
      if (memBe[0]) mem[{memAddr[8:1], 1'b0}] <= memWdata[7:0];
      if (memBe[1]) mem[{memAddr[8:1], 1'b1}] <= memWdata[15:8];
    end
  end

  always @(negedge clk) gntOk <= ($urandom % 4) != 0;

  int reqRises = 0;
  logic prevReq = 1'b0;
  always @(posedge clk) begin
    prevReq <= busReq;
    if (busReq && !prevReq) reqRises <= reqRises + 1;
  end

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stepOf(input int a, input logic [1:0] code, input bit isByte);
    int d = isByte ? 1 : 2;
    if (code == 2'd3) return a + d;
    if (code == 2'd2) return a - d;
    return a;
  endfunction

  task automatic refMove(input bit sb, input bit db, input logic [1:0] ss,
                         input logic [1:0] ds, input int sa, input int da, input int n);
    logic [15:0] v;
    for (int k = 0; k < n; k++) begin
      if (sb) v = {8'h00, expMem[sa]};
      else    v = {expMem[sa | 1], expMem[sa & ~1]};
      if (db) expMem[da] = v[7:0];
      else begin
        expMem[da & ~1] = v[7:0];
        expMem[da | 1]  = v[15:8];
      end
      sa = stepOf(sa, ss, sb);
      da = stepOf(da, ds, db);
    end
  endtask

  task automatic fillMem();
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'($urandom);
      expMem[i] = mem[i];
    end
  endtask

  task automatic cmpMem(input string tag);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== expMem[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic cfgWrite(input logic [2:0] m, input int cnt, input int sel,
                          input bit lvl, input bit sb, input bit db,
                          input logic [1:0] ss, input logic [1:0] ds,
                          input int sa, input int da);
    @(negedge clk);
    cfgMode = m; cfgCount = 16'(cnt); cfgTrigSel = 5'(sel); cfgLevel = lvl;
    cfgSrcByte = sb; cfgDstByte = db; cfgSrcStep = ss; cfgDstStep = ds;
    cfgSrcAddr = 16'(sa); cfgDstAddr = 16'(da); cfgLoad = 1;
    @(negedge clk) cfgLoad = 0;
  endtask

  task automatic pulseEn();
    @(negedge clk) enSet = 1;
    @(negedge clk) enSet = 0;
  endtask
  task automatic pulseDis();
    @(negedge clk) enClr = 1;
    @(negedge clk) enClr = 0;
  endtask
  task automatic pulseClr();
    @(negedge clk) flagClr = 1;
    @(negedge clk) flagClr = 0;
  endtask
  task automatic pulseSw();
    @(negedge clk) swStart = 1;
    @(negedge clk) swStart = 0;
  endtask

  task automatic waitIdle();
    int low = 0;
    for (int c = 0; c < 3000 && low < 6; c++) begin
      @(negedge clk);
      if (busReq) low = 0; else low++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 enOut", enOut, 0);
    chk("R11 flagOut", flagOut, 0);
    chk("R11 irqOut", irqOut, 0);
    chk("R11 busReq", busReq, 0);
    chk("R11 memRd|memWr", memRd | memWr, 0);

    // R1 single mode: one unit per software start, word/word increment
    fillMem();
    cfgWrite(3'd0, 3, 0, 0, 0, 0, 2'd3, 2'd3, 100, 300);
    pulseEn();
    reqRises = 0;
    pulseSw(); waitIdle();
    chk("R1 single one request", reqRises, 1);
    chk("R3 single not done en", enOut, 1);
    chk("R3 single not done flag", flagOut, 0);
    pulseSw(); waitIdle();
    pulseSw(); waitIdle();
    chk("R9 single request per start", reqRises, 3);
    chk("R3 single done flag", flagOut, 1);
    chk("R3 single done en cleared", enOut, 0);
    refMove(0, 0, 2'd3, 2'd3, 100, 300, 3);
    cmpMem("R4 single word inc data");
    pulseClr();

    // R6 block on trigIn[5]; others ignored; byte src inc -> word dst dec (R5)
    fillMem();
    cfgWrite(3'd1, 4, 5, 0, 1, 0, 2'd3, 2'd2, 101, 400);
    pulseEn();
    reqRises = 0;
    pulseSw();
    @(negedge clk) trigIn[6] = 1;
    @(negedge clk) trigIn[6] = 0;
    waitIdle();
    chk("R6 unselected lines ignored", reqRises, 0);
    cmpMem("R6 memory untouched");
    @(negedge clk) trigIn[5] = 1;
    @(negedge clk) trigIn[5] = 0;
    waitIdle();
    chk("R1 block one request", reqRises, 1);
    chk("R3 block flag", flagOut, 1);
    chk("R3 block en cleared", enOut, 0);
    refMove(1, 0, 2'd3, 2'd2, 101, 400, 4);
    cmpMem("R5 byte to word zero upper");

    // R8 flag gating and clearing
    @(negedge clk) irqEn = 0;
    @(negedge clk);
    chk("R8 irq masked", irqOut, 0);
    irqEn = 1;
    @(negedge clk);
    chk("R8 irq passes", irqOut, 1);
    pulseEn();
    chk("R8 enable keeps flag", flagOut, 1);
    pulseClr();
    chk("R8 clear flag", flagOut, 0);
    chk("R8 clear irq", irqOut, 0);
    pulseDis();
    irqEn = 0;

    // R2 count zero
    fillMem();
    cfgWrite(3'd1, 0, 0, 0, 0, 0, 2'd3, 2'd3, 120, 320);
    pulseEn();
    reqRises = 0;
    pulseSw(); waitIdle();
    chk("R2 no request", reqRises, 0);
    chk("R2 no flag", flagOut, 0);
    cmpMem("R2 no data moved");
    pulseDis();

    // R1 burst-block: word src -> byte dst, 9 units, bursts of 4
    fillMem();
    cfgWrite(3'd2, 9, 0, 0, 0, 1, 2'd3, 2'd3, 140, 341);
    pulseEn();
    reqRises = 0;
    pulseSw(); waitIdle();
    chk("R1 burst request count", reqRises, 3);
    chk("R3 burst flag", flagOut, 1);
    chk("R3 burst en cleared", enOut, 0);
    refMove(0, 1, 2'd3, 2'd3, 140, 341, 9);
    cmpMem("R5 word to byte low byte");
    pulseClr();

    // R1 repeated block: reload and stay enabled
    fillMem();
    cfgWrite(3'd5, 3, 0, 0, 0, 0, 2'd3, 2'd3, 200, 260);
    pulseEn();
    pulseSw(); waitIdle();
    refMove(0, 0, 2'd3, 2'd3, 200, 260, 3);
    cmpMem("R1 repeat first pass");
    chk("R1 repeat en stays", enOut, 1);
    chk("R3 repeat flag", flagOut, 1);
    pulseClr();
    for (int i = 200; i < 206; i++) begin
      mem[i] = 8'($urandom);
      expMem[i] = mem[i];
    end
    pulseSw(); waitIdle();
    refMove(0, 0, 2'd3, 2'd3, 200, 260, 3);
    cmpMem("R1 repeat reloaded addresses");
    chk("R1 repeat en still set", enOut, 1);
    pulseDis();
    pulseClr();

    // R7 level held high: repeats until count done
    fillMem();
    cfgWrite(3'd0, 4, 9, 1, 1, 1, 2'd3, 2'd0, 150, 350);
    pulseEn();
    reqRises = 0;
    @(negedge clk) trigIn[9] = 1;
    waitIdle();
    trigIn[9] = 0;
    chk("R7 level transfers", reqRises, 4);
    chk("R7 level en cleared", enOut, 0);
    refMove(1, 1, 2'd3, 2'd0, 150, 350, 4);
    cmpMem("R4 hold destination");
    pulseClr();
    // R7 edge held high: only one
    cfgWrite(3'd0, 4, 9, 0, 1, 1, 2'd3, 2'd0, 150, 350);
    pulseEn();
    reqRises = 0;
    @(negedge clk) trigIn[9] = 1;
    waitIdle();
    trigIn[9] = 0;
    chk("R7 edge single transfer", reqRises, 1);
    chk("R7 edge no flag", flagOut, 0);
    pulseDis();

    // R10 load ignored while enabled
    fillMem();
    cfgWrite(3'd1, 2, 0, 0, 0, 0, 2'd3, 2'd3, 120, 320);
    pulseEn();
    cfgWrite(3'd1, 5, 0, 0, 0, 0, 2'd3, 2'd3, 140, 340);
    pulseSw(); waitIdle();
    refMove(0, 0, 2'd3, 2'd3, 120, 320, 2);
    cmpMem("R10 load ignored while enabled");
    chk("R10 flag", flagOut, 1);
    pulseClr();

    // random mix for R1 R4 R5
    for (int it = 0; it < 20; it++) begin
      int m = $urandom % 3;
      int n = 1 + ($urandom % 6);
      bit sb = 1'($urandom), db = 1'($urandom);
      logic [1:0] ss = ($urandom % 3 == 0) ? 2'd0 : 2'(2 + $urandom % 2);
      logic [1:0] ds = ($urandom % 3 == 0) ? 2'd0 : 2'(2 + $urandom % 2);
      int sa = 150 + ($urandom % 60);
      int da = 330 + ($urandom % 60);
      if (!sb) sa = sa & ~1;
      if (!db) da = da & ~1;
      fillMem();
      cfgWrite(3'(m), n, 0, 0, sb, db, ss, ds, sa, da);
      pulseEn();
      if (m == 0) for (int k = 0; k < n; k++) begin pulseSw(); waitIdle(); end
      else begin pulseSw(); waitIdle(); end
      refMove(sb, db, ss, ds, sa, da, n);
      cmpMem($sformatf("R4 R5 random mode %0d iter %0d", m, it));
      chk("R3 random flag", flagOut, 1);
      chk("R3 random en", enOut, 0);
      pulseClr();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule